// File: doc/BRIEF.md
# Dual-Enable Half-Word Static Memory

This block is a synthesizable model of an asynchronous static memory of 32-bit words with a 17-bit address. Two chip enables of opposite polarity must both be active to select it. An active-low write strobe and an active-low output enable pick the operation. Two active-low lane enables each cover one 16-bit half of the word. When the block is not selected it sits in standby and drives nothing, whatever the other pins do.

The bidirectional data bus is split into three parts so that it can be synthesized: a 32-bit write-data input, a 32-bit read-data output, and one drive flag per 16-bit lane. An enclosing pad ring or bus mux turns these into a tri-state bus. A raised drive flag means the lane is driven. A lowered flag means the lane is high-impedance, and that lane of the read-data output reads as zero.

The asynchronous control pins are sampled on a fast clock. While a write is active, the address, the write data and the lane mask are captured on every clock. The write is committed when the sampled write condition ends. It can end by the write strobe rising or by either chip enable going inactive. The stored data are therefore the values present just before the terminating edge. Reads are combinational from the array. The array depth is a parameter, and only the low address bits that index the array are decoded.

Top module: `sram_hw_array`

## Requirements
- R1: A read returns the word last committed at the array index given by the low clog2(DEPTH) address bits. Address bits above the index do not take part in the decode.
- R2: When `chipSelN` is high or `chipSel` is low, both lane drive flags are 0, `rdData` is 0, and any write attempt leaves the array unchanged.
- R3: When selected with `wrN` high and `oeN` low, lane 0 (bits 15:0) is driven exactly when `laneLoN` is low, and lane 1 (bits 31:16) is driven exactly when `laneHiN` is low. Each driven lane carries its half of the addressed word.
- R4: When selected with `wrN` low, a write takes place whatever the level of `oeN`. Only the lanes whose enable is low are updated, and the other lane keeps its old contents.
- R5: Both drive flags are 0 whenever `oeN` is high or `wrN` is low.
- R6: When both lane enables are high, no lane is driven and no write takes place, even while selected.
- R7: The write commits in the clock edge after the write condition (selected and `wrN` low) is last sampled true. It stores the address, data and lane mask sampled on that last active edge. It ends in the same way whether `wrN` rises or a chip enable drops.
- R8: During an active read, `rdData` follows an address change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the asynchronous controls |
| rstN | input | 1 | Active-low reset of the control and capture state |
| chipSelN | input | 1 | Active-low chip enable |
| chipSel | input | 1 | Active-high chip enable |
| wrN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| laneLoN | input | 1 | Active-low enable of bits 15:0 |
| laneHiN | input | 1 | Active-low enable of bits 31:16 |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero on undriven lanes |
| laneDrive | output | 2 | Per-lane drive flag, bit 1 = upper lane |

## Verification
The hardest case to reach is a write whose data change while it is active and which then ends through a chip enable rather than through the strobe. The bench holds `wrN` low across several clocks, changes `wrData` and the lane mask between them, and then drops `chipSel` or raises `chipSelN`. A full-word read afterwards must show only the last sampled value. Single-lane writes over a known full word, and writes attempted in standby or with both lanes masked, are each followed by full-word reads. These reads expose any lane that leaked.

// File: rtl/sram_hw_pkg.sv
package sram_hw_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 2;
  localparam int LANE_W = WORD_W / LANES;

  typedef struct packed {
    logic             capture;
    logic             commit;
    logic [LANES-1:0] commitMask;
    logic [LANES-1:0] driveMask;
  } sramStrobes_t;
endpackage

// File: rtl/sram_hw_ctrl.sv
module sram_hw_ctrl
  import sram_hw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             chipSel,
  input  logic             wrN,
  input  logic             oeN,
  input  logic [LANES-1:0] laneEnN,
  output sramStrobes_t     strobes
);
  logic selected, writeAct, readAct, prevWrite;
  logic [LANES-1:0] maskQ;

  assign selected = !chipSelN && chipSel;
  assign writeAct = selected && !wrN;
  assign readAct  = selected && wrN && !oeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWrite <= 1'b0;
      maskQ     <= '0;
    end else begin
      prevWrite <= writeAct;
      if (writeAct) maskQ <= ~laneEnN;
    end
  end

  always_comb begin
    strobes.capture    = writeAct;
    strobes.commit     = prevWrite && !writeAct;
    strobes.commitMask = maskQ;
    strobes.driveMask  = readAct ? ~laneEnN : '0;
  end

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN || !chipSel) |-> strobes.driveMask == '0);
  assert_no_drive_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || !wrN) |-> strobes.driveMask == '0);
  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (laneEnN == '1) |-> strobes.driveMask == '0);
  assert_commit_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> $past(!chipSelN && chipSel && !wrN));
endmodule

// File: rtl/sram_hw_datapath.sv
module sram_hw_datapath
  import sram_hw_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  capIdx;
  logic [WORD_W-1:0] capData;
  logic [WORD_W-1:0] rdWord;
  logic [IDX_W-1:0]  rdIdx;

  assign rdIdx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx  <= '0;
      capData <= '0;
    end else if (strobes.capture) begin
      capIdx  <= addr[IDX_W-1:0];
      capData <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strobes.commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (strobes.commitMask[l])
          mem[capIdx][l*LANE_W +: LANE_W] <= capData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdWord = mem[rdIdx];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdData[g*LANE_W +: LANE_W] =
      strobes.driveMask[g] ? rdWord[g*LANE_W +: LANE_W] : '0;
  end

  assert_undriven_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.driveMask[0] |-> rdData[LANE_W-1:0] == '0);
endmodule

// File: rtl/sram_hw_array.sv
module sram_hw_array
  import sram_hw_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chipSel,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              laneLoN,
  input  logic              laneHiN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [1:0]        laneDrive
);
  sramStrobes_t strobes;

  sram_hw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSel(chipSel),
    .wrN(wrN), .oeN(oeN), .laneEnN({laneHiN, laneLoN}), .strobes(strobes)
  );

  sram_hw_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  assign laneDrive = strobes.driveMask;

  assert_lane_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    laneDrive[1] |-> (!laneHiN && wrN && !oeN));
endmodule

// File: tb/tb_sram_hw_array.sv
module tb_sram_hw_array;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int DEPTH  = 256;

  logic clk = 0, rstN = 0;
  logic chipSelN = 1, chipSel = 0, wrN = 1, oeN = 1, laneLoN = 1, laneHiN = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [1:0] laneDrive;

  int checks = 0, errors = 0;
  logic [31:0] shadow [int];
  bit pendValid = 0;
  int pendIdx;
  logic [31:0] pendData;
  logic [1:0] pendMask;

  sram_hw_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: expired, actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: compares drive flags and read data after every clock
  task automatic cyc(string tag, bit sN, bit s, bit w, bit o, bit lo, bit hi,
                     int a, logic [31:0] d);
    bit sel, wAct, rAct;
    logic [1:0] expDrv;
    logic [31:0] expData;
    int idx;
    chipSelN = sN; chipSel = s; wrN = w; oeN = o; laneLoN = lo; laneHiN = hi;
    addr = ADDR_W'(a); wrData = d;
    @(posedge clk);
    sel = !sN && s; wAct = sel && !w; rAct = sel && w && !o;
    if (pendValid && !wAct) begin
      logic [31:0] old = shadow.exists(pendIdx) ? shadow[pendIdx] : 32'h0;
      if (pendMask[0]) old[15:0]  = pendData[15:0];
      if (pendMask[1]) old[31:16] = pendData[31:16];
      if (pendMask != 0) shadow[pendIdx] = old;
    end
    pendValid = wAct;
    if (wAct) begin pendIdx = a % DEPTH; pendData = d; pendMask = {!hi, !lo}; end
    @(negedge clk);
    expDrv = rAct ? {!hi, !lo} : 2'b00;
    chk({tag, " drive"}, {30'h0, laneDrive}, {30'h0, expDrv});
    idx = a % DEPTH;
    if (expDrv != 0 && shadow.exists(idx)) begin
      expData = shadow[idx];
      if (!expDrv[0]) expData[15:0] = 16'h0;
      if (!expDrv[1]) expData[31:16] = 16'h0;
      chk({tag, " data"}, rdData, expData);
    end
  endtask

  task automatic idle(string tag);
    cyc(tag, 1, 0, 1, 1, 1, 1, 0, 32'h0);
  endtask

  task automatic wr(string tag, int a, logic [31:0] d, bit lo, bit hi);
    cyc(tag, 0, 1, 0, 0, lo, hi, a, d);
    idle(tag);
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 0, 1, 1, 0, 0, 0, a, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    idle("R2 reset");
    chk("R2 reset rdData", rdData, 32'h0);

    // R1: full-word writes and reads at several addresses
    for (int i = 0; i < 8; i++) wr("R1 fill", i * 31, 32'hA5A50000 + i * 32'h01010101, 0, 0);
    for (int i = 0; i < 8; i++) rd("R1 read", i * 31);
    rd("R1 alias", 31 + DEPTH);
    chk("R1 alias explicit", rdData, 32'hA5A50000 + 32'h01010101);

    // R3: single-lane reads
    cyc("R3 low lane", 0, 1, 1, 0, 0, 1, 62, 32'h0);
    cyc("R3 high lane", 0, 1, 1, 0, 1, 0, 62, 32'h0);
    // R5: outputs off with oeN high or wrN low
    cyc("R5 oe high", 0, 1, 1, 1, 0, 0, 62, 32'h0);
    // R6: masked read
    cyc("R6 masked read", 0, 1, 1, 0, 1, 1, 62, 32'h0);

    // R4: lane writes, oeN high during one of them
    wr("R4 low lane", 93, 32'h1111BEEF, 0, 1);
    rd("R4 low lane read", 93);
    cyc("R4 oe high write", 0, 1, 0, 1, 1, 0, 124, 32'hCAFE2222);
    idle("R4 oe high write");
    rd("R4 high lane read", 124);

    // R2: writes attempted in standby must not land
    cyc("R2 standby write a", 1, 1, 0, 0, 0, 0, 0, 32'hDEADDEAD);
    cyc("R2 standby write b", 0, 0, 0, 0, 0, 0, 0, 32'hDEADDEAD);
    idle("R2 standby write");
    rd("R2 after standby", 0);
    chk("R2 array kept", rdData, 32'hA5A50000);

    // R6: write with both lanes masked must not land
    wr("R6 masked write", 31, 32'h0BADF00D, 1, 1);
    rd("R6 after masked", 31);

    // R7: long write, data changes, terminated by chipSel dropping
    cyc("R7 w1", 0, 1, 0, 0, 0, 0, 155, 32'h00000001);
    cyc("R7 w2", 0, 1, 0, 0, 0, 1, 155, 32'h77770002);
    cyc("R7 w3", 0, 1, 0, 0, 0, 0, 155, 32'h12345678);
    cyc("R7 end enable", 0, 0, 0, 0, 0, 0, 155, 32'hFFFFFFFF);
    idle("R7 gap");
    rd("R7 read", 155);
    chk("R7 last data kept", rdData, 32'h12345678);
    // terminated by chipSelN rising
    cyc("R7 v1", 0, 1, 0, 0, 0, 0, 186, 32'h99990000);
    cyc("R7 v2", 0, 1, 0, 0, 1, 0, 186, 32'h4444AAAA);
    cyc("R7 end selN", 1, 1, 0, 0, 0, 0, 186, 32'h0);
    rd("R7 read b", 186);
    // terminated by wrN rising, read in the very next cycle
    cyc("R7 u1", 0, 1, 0, 0, 0, 0, 217, 32'h5A5A5A5A);
    rd("R7 wr rise", 217);
    rd("R7 wr read", 217);

    // R8: address change during read reflected before any edge
    cyc("R8 setup", 0, 1, 1, 0, 0, 0, 0, 32'h0);
    addr = ADDR_W'(62);
    #1;
    chk("R8 comb read", rdData, 32'hA5A50000 + 2 * 32'h01010101);

    idle("end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule